// File: doc/BRIEF.md
# Home-Node Coherence Directory with Stale-Owner Recovery

This block is the directory for the blocks that one memory home node owns. For each block it records one of three states: uncached, shared by a set of nodes, or held exclusively by one node. It accepts read requests (shared copy wanted) and ownership requests (writable copy wanted) from four nodes. It sends invalidations to sharers, forwards requests to an exclusive holder and issues grants that carry the block's data. It also holds the block contents in a small on-chip memory.

Caches may turn an exclusive copy into a modified one without telling the directory, and may drop a clean exclusive copy without telling it either. The directory therefore treats every exclusive grant as a possibly dirty copy and forwards every later miss on that block to the recorded holder. A holder that has quietly dropped the block answers the forward with a NACK. The directory then serves the requester from its own memory. The directory handles one transaction at a time. While a forward or an invalidation round is open, new requests are held off with `req_ready` low, so racing requests are served strictly in the order they are accepted.

Top module: `dir_home`

## Requirements
- R1: After reset, `req_ready` is 1, `gnt_valid`, `fwd_valid` and `inv_valid` are 0, and every block is uncached. Block b initially holds the low DW bits of 0xA000 + 0x111·b.
- R2: A request of either kind (`req_op` 0 = read, 1 = ownership) to an uncached block is granted exclusive (`gnt_excl`=1) to the requester one cycle after acceptance, with the memory contents. The requester becomes the recorded holder.
- R3: A read request to a shared block is granted shared (`gnt_excl`=0) one cycle after acceptance, with the memory contents. The requester is added to the sharer set.
- R4: An ownership request to a shared block pulses `inv_valid` one cycle after acceptance, with `inv_mask` holding the sharers other than the requester (bit i = node i). No grant is issued until each of those nodes has answered with `rsp_kind` 2. The exclusive grant follows one cycle after the last such answer.
- R5: A request to a block held exclusively by another node pulses `fwd_valid` one cycle after acceptance, carrying the holder's id, the request kind and the block. `req_ready` stays 0 until the holder replies.
- R6: A data reply (`rsp_kind` 0) from the holder writes `rsp_data` into memory and produces a grant one cycle later that carries `rsp_data`. For a read, the grant is shared and both holder and requester become sharers. For an ownership request, the grant is exclusive and the requester becomes the holder.
- R7: A NACK (`rsp_kind` 1) from the holder produces an exclusive grant one cycle later, carrying the unchanged memory contents. The requester becomes the holder.
- R8: A request from the recorded holder itself is served from memory as an exclusive grant one cycle after acceptance, with no forward.
- R9: A reply that arrives while idle, or that comes from a node other than the awaited holder, produces no grant and changes neither memory nor state.
- R10: Requests are served in acceptance order. A request held while the directory is busy is accepted in the cycle its predecessor's grant appears, and it is then forwarded to the new holder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_node | input | NW | Requesting node id |
| req_op | input | 1 | 0 = read (shared), 1 = ownership |
| req_blk | input | BW | Block index |
| req_ready | output | 1 | Directory idle, request accepted when valid |
| fwd_valid | output | 1 | Forward pulse to the recorded holder |
| fwd_node | output | NW | Holder being forwarded to |
| fwd_op | output | 1 | Kind of the forwarded request |
| fwd_blk | output | BW | Block of the forwarded request |
| inv_valid | output | 1 | Invalidation pulse |
| inv_mask | output | NN | Nodes to invalidate |
| inv_blk | output | BW | Block being invalidated |
| rsp_valid | input | 1 | Node reply present |
| rsp_node | input | NW | Replying node id |
| rsp_kind | input | 2 | 0 data, 1 NACK, 2 invalidation ack |
| rsp_data | input | DW | Block data carried by a data reply |
| gnt_valid | output | 1 | Grant pulse |
| gnt_node | output | NW | Node receiving the grant |
| gnt_excl | output | 1 | 1 exclusive, 0 shared |
| gnt_blk | output | BW | Granted block |
| gnt_data | output | DW | Block contents delivered |

## Verification
Every directory action is registered. A grant, forward or invalidation pulse therefore appears in the cycle after the clock edge that accepted the request or the deciding reply. The bench drives each request or reply on a falling edge and samples the outputs on the next falling edge. It also confirms that no grant appears in the cycles of an open invalidation round or forward, and in the cycles after an ignored reply. The reference model updates its per-block state only when the grant it predicts is seen. Each later transaction is predicted from that model, so a wrong holder, sharer set or memory word shows up in a later grant or forward.

// File: rtl/dir_pkg.sv
package dir_pkg;

  typedef enum logic [1:0] {
    DIR_UNC = 2'd0,
    DIR_SHR = 2'd1,
    DIR_OWN = 2'd2
  } dir_st_e;

  typedef enum logic [1:0] {
    CT_IDLE = 2'd0,
    CT_FWD  = 2'd1,
    CT_INV  = 2'd2
  } ctl_st_e;

  localparam logic       OP_READ = 1'b0;
  localparam logic       OP_OWN  = 1'b1;
  localparam logic [1:0] RK_DATA = 2'd0;
  localparam logic [1:0] RK_NACK = 2'd1;
  localparam logic [1:0] RK_IACK = 2'd2;

  // Initial memory word of block b.
  function automatic logic [31:0] seed_word(input int unsigned b);
    return 32'h0000_A000 + 32'(b) * 32'h0000_0111;
  endfunction

  // A request is served from memory immediately when nobody holds the
  // block, or when the holder itself asks again.
  function automatic logic direct_serve(input dir_st_e st, input logic self_owner);
    return (st == DIR_UNC) || (st == DIR_OWN && self_owner);
  endfunction

endpackage

// File: rtl/dir_table.sv
module dir_table
  import dir_pkg::*;
#(
  parameter int NBLK = 8,
  parameter int NN   = 4,
  parameter int DW   = 16,
  parameter int BW   = 3,
  parameter int NW   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] acc_blk,
  output dir_st_e       rd_st,
  output logic [NN-1:0] rd_shr,
  output logic [NW-1:0] rd_own,
  output logic [DW-1:0] rd_data,
  input  logic          upd_en,
  input  dir_st_e       upd_st,
  input  logic [NN-1:0] upd_shr,
  input  logic [NW-1:0] upd_own,
  input  logic          mem_we,
  input  logic [DW-1:0] mem_wd
);

  dir_st_e       st_q  [NBLK];
  logic [NN-1:0] shr_q [NBLK];
  logic [NW-1:0] own_q [NBLK];
  logic [DW-1:0] mem_q [NBLK];

  assign rd_st   = st_q[acc_blk];
  assign rd_shr  = shr_q[acc_blk];
  assign rd_own  = own_q[acc_blk];
  assign rd_data = mem_q[acc_blk];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBLK; i++) begin
        st_q[i]  <= DIR_UNC;
        shr_q[i] <= '0;
        own_q[i] <= '0;
        mem_q[i] <= DW'(seed_word(i));
      end
    end else begin
      if (upd_en) begin
        st_q[acc_blk]  <= upd_st;
        shr_q[acc_blk] <= upd_shr;
        own_q[acc_blk] <= upd_own;
      end
      if (mem_we) mem_q[acc_blk] <= mem_wd;
    end
  end

endmodule

// File: rtl/dir_ack_tracker.sv
module dir_ack_tracker #(
  parameter int NN = 4,
  parameter int NW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [NN-1:0] load_mask,
  input  logic          ack_valid,
  input  logic [NW-1:0] ack_node,
  output logic          last_ack
);

  logic [NN-1:0] pend_q;
  logic [NN-1:0] pend_nxt;
  logic [NN-1:0] ack_bit;

  for (genvar i = 0; i < NN; i++) begin : g_bit
    assign ack_bit[i] = ack_valid && (ack_node == NW'(i));
  end

  assign pend_nxt = load ? load_mask : (pend_q & ~ack_bit);
  // Only an ack that retires a still-pending bit can close the round.
  assign last_ack = !load && (|(pend_q & ack_bit)) && (pend_nxt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_nxt;
  end

endmodule

// File: rtl/dir_ctrl.sv
module dir_ctrl
  import dir_pkg::*;
#(
  parameter int NN = 4,
  parameter int DW = 16,
  parameter int BW = 3,
  parameter int NW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [NW-1:0] req_node,
  input  logic          req_op,
  input  logic [BW-1:0] req_blk,
  output logic          req_ready,
  input  logic          rsp_valid,
  input  logic [NW-1:0] rsp_node,
  input  logic [1:0]    rsp_kind,
  input  logic [DW-1:0] rsp_data,
  output logic [BW-1:0] acc_blk,
  input  dir_st_e       rd_st,
  input  logic [NN-1:0] rd_shr,
  input  logic [NW-1:0] rd_own,
  input  logic [DW-1:0] rd_data,
  output logic          upd_en,
  output dir_st_e       upd_st,
  output logic [NN-1:0] upd_shr,
  output logic [NW-1:0] upd_own,
  output logic          mem_we,
  output logic [DW-1:0] mem_wd,
  output logic          trk_load,
  output logic [NN-1:0] trk_mask,
  output logic          trk_ack,
  input  logic          trk_last,
  output logic          fwd_valid,
  output logic [NW-1:0] fwd_node,
  output logic          fwd_op,
  output logic [BW-1:0] fwd_blk,
  output logic          inv_valid,
  output logic [NN-1:0] inv_mask,
  output logic [BW-1:0] inv_blk,
  output logic          gnt_valid,
  output logic [NW-1:0] gnt_node,
  output logic          gnt_excl,
  output logic [BW-1:0] gnt_blk,
  output logic [DW-1:0] gnt_data,
  output logic          ev_nack,
  output logic          ev_owner_data,
  output logic          ev_data_read,
  output logic          ev_inv_done
);

  ctl_st_e       st_q, st_nxt;
  logic [NW-1:0] cur_node_q, cur_own_q;
  logic          cur_op_q;
  logic [BW-1:0] cur_blk_q;

  logic [NN-1:0] req_bit, cur_bit, own_bit, others;
  logic          accept, holder_rsp;
  logic          g_fire, g_excl;
  logic [DW-1:0] g_data;
  logic          f_fire, i_fire;

  for (genvar i = 0; i < NN; i++) begin : g_node
    assign req_bit[i] = (req_node  == NW'(i));
    assign cur_bit[i] = (cur_node_q == NW'(i));
    assign own_bit[i] = (cur_own_q  == NW'(i));
  end

  assign req_ready     = (st_q == CT_IDLE);
  assign accept        = req_ready && req_valid;
  assign acc_blk       = req_ready ? req_blk : cur_blk_q;
  assign others        = rd_shr & ~req_bit;
  assign holder_rsp    = (st_q == CT_FWD) && rsp_valid && (rsp_node == cur_own_q);
  assign ev_owner_data = holder_rsp && (rsp_kind == RK_DATA);
  assign ev_nack       = holder_rsp && (rsp_kind == RK_NACK);
  assign ev_data_read  = ev_owner_data && (cur_op_q == OP_READ);
  assign trk_ack       = (st_q == CT_INV) && rsp_valid && (rsp_kind == RK_IACK);
  assign ev_inv_done   = (st_q == CT_INV) && trk_last;
  assign trk_load      = i_fire;
  assign trk_mask      = others;
  assign mem_wd        = rsp_data;
  assign mem_we        = ev_owner_data;

  always_comb begin
    st_nxt  = st_q;
    g_fire  = 1'b0;
    g_excl  = 1'b1;
    g_data  = rd_data;
    f_fire  = 1'b0;
    i_fire  = 1'b0;
    upd_en  = 1'b0;
    upd_st  = DIR_OWN;
    upd_shr = '0;
    upd_own = req_ready ? req_node : cur_node_q;
    unique case (st_q)
      CT_IDLE: if (accept) begin
        if (direct_serve(rd_st, rd_own == req_node)) begin
          g_fire = 1'b1;
          upd_en = 1'b1;
        end else if (rd_st == DIR_SHR) begin
          if (req_op == OP_READ) begin
            g_fire  = 1'b1;
            g_excl  = 1'b0;
            upd_en  = 1'b1;
            upd_st  = DIR_SHR;
            upd_shr = rd_shr | req_bit;
          end else if (others == '0) begin
            g_fire = 1'b1;
            upd_en = 1'b1;
          end else begin
            i_fire = 1'b1;
            st_nxt = CT_INV;
          end
        end else begin
          f_fire = 1'b1;
          st_nxt = CT_FWD;
        end
      end
      CT_FWD: if (ev_owner_data) begin
        g_fire = 1'b1;
        g_data = rsp_data;
        upd_en = 1'b1;
        st_nxt = CT_IDLE;
        if (cur_op_q == OP_READ) begin
          g_excl  = 1'b0;
          upd_st  = DIR_SHR;
          upd_shr = cur_bit | own_bit;
        end
      end else if (ev_nack) begin
        g_fire = 1'b1;
        upd_en = 1'b1;
        st_nxt = CT_IDLE;
      end
      CT_INV: if (ev_inv_done) begin
        g_fire = 1'b1;
        upd_en = 1'b1;
        st_nxt = CT_IDLE;
      end
      default: st_nxt = CT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= CT_IDLE;
      cur_node_q <= '0;
      cur_own_q  <= '0;
      cur_op_q   <= OP_READ;
      cur_blk_q  <= '0;
      fwd_valid  <= 1'b0;
      fwd_node   <= '0;
      fwd_op     <= 1'b0;
      fwd_blk    <= '0;
      inv_valid  <= 1'b0;
      inv_mask   <= '0;
      inv_blk    <= '0;
      gnt_valid  <= 1'b0;
      gnt_node   <= '0;
      gnt_excl   <= 1'b0;
      gnt_blk    <= '0;
      gnt_data   <= '0;
    end else begin
      st_q      <= st_nxt;
      fwd_valid <= f_fire;
      inv_valid <= i_fire;
      gnt_valid <= g_fire;
      if (accept) begin
        cur_node_q <= req_node;
        cur_own_q  <= rd_own;
        cur_op_q   <= req_op;
        cur_blk_q  <= req_blk;
      end
      if (f_fire) begin
        fwd_node <= rd_own;
        fwd_op   <= req_op;
        fwd_blk  <= req_blk;
      end
      if (i_fire) begin
        inv_mask <= others;
        inv_blk  <= req_blk;
      end
      if (g_fire) begin
        gnt_node <= upd_own;
        gnt_excl <= g_excl;
        gnt_blk  <= acc_blk;
        gnt_data <= g_data;
      end
    end
  end

endmodule

// File: rtl/dir_home.sv
module dir_home
  import dir_pkg::*;
#(
  parameter int NBLK = 8,
  parameter int NN   = 4,
  parameter int DW   = 16,
  localparam int BW  = (NBLK > 1) ? $clog2(NBLK) : 1,
  localparam int NW  = (NN > 1) ? $clog2(NN) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [NW-1:0] req_node,
  input  logic          req_op,
  input  logic [BW-1:0] req_blk,
  output logic          req_ready,
  output logic          fwd_valid,
  output logic [NW-1:0] fwd_node,
  output logic          fwd_op,
  output logic [BW-1:0] fwd_blk,
  output logic          inv_valid,
  output logic [NN-1:0] inv_mask,
  output logic [BW-1:0] inv_blk,
  input  logic          rsp_valid,
  input  logic [NW-1:0] rsp_node,
  input  logic [1:0]    rsp_kind,
  input  logic [DW-1:0] rsp_data,
  output logic          gnt_valid,
  output logic [NW-1:0] gnt_node,
  output logic          gnt_excl,
  output logic [BW-1:0] gnt_blk,
  output logic [DW-1:0] gnt_data
);

  logic [BW-1:0] acc_blk;
  dir_st_e       rd_st, upd_st;
  logic [NN-1:0] rd_shr, upd_shr, trk_mask;
  logic [NW-1:0] rd_own, upd_own;
  logic [DW-1:0] rd_data, mem_wd;
  logic          upd_en, mem_we, trk_load, trk_ack, trk_last;
  logic          ev_nack, ev_owner_data, ev_data_read, ev_inv_done;

  dir_table #(.NBLK(NBLK), .NN(NN), .DW(DW), .BW(BW), .NW(NW)) u_table (
    .clk(clk), .rst_n(rst_n), .acc_blk(acc_blk),
    .rd_st(rd_st), .rd_shr(rd_shr), .rd_own(rd_own), .rd_data(rd_data),
    .upd_en(upd_en), .upd_st(upd_st), .upd_shr(upd_shr), .upd_own(upd_own),
    .mem_we(mem_we), .mem_wd(mem_wd)
  );

  dir_ack_tracker #(.NN(NN), .NW(NW)) u_track (
    .clk(clk), .rst_n(rst_n), .load(trk_load), .load_mask(trk_mask),
    .ack_valid(trk_ack), .ack_node(rsp_node), .last_ack(trk_last)
  );

  dir_ctrl #(.NN(NN), .DW(DW), .BW(BW), .NW(NW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_node(req_node), .req_op(req_op),
    .req_blk(req_blk), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_node(rsp_node), .rsp_kind(rsp_kind),
    .rsp_data(rsp_data),
    .acc_blk(acc_blk), .rd_st(rd_st), .rd_shr(rd_shr), .rd_own(rd_own),
    .rd_data(rd_data), .upd_en(upd_en), .upd_st(upd_st), .upd_shr(upd_shr),
    .upd_own(upd_own), .mem_we(mem_we), .mem_wd(mem_wd),
    .trk_load(trk_load), .trk_mask(trk_mask), .trk_ack(trk_ack),
    .trk_last(trk_last),
    .fwd_valid(fwd_valid), .fwd_node(fwd_node), .fwd_op(fwd_op),
    .fwd_blk(fwd_blk), .inv_valid(inv_valid), .inv_mask(inv_mask),
    .inv_blk(inv_blk), .gnt_valid(gnt_valid), .gnt_node(gnt_node),
    .gnt_excl(gnt_excl), .gnt_blk(gnt_blk), .gnt_data(gnt_data),
    .ev_nack(ev_nack), .ev_owner_data(ev_owner_data),
    .ev_data_read(ev_data_read), .ev_inv_done(ev_inv_done)
  );

endmodule

// File: rtl/dir_home_chk.sv
module dir_home_chk #(
  parameter int NN = 4,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          fwd_valid,
  input logic          inv_valid,
  input logic [NN-1:0] inv_mask,
  input logic          gnt_valid,
  input logic          gnt_excl,
  input logic [DW-1:0] gnt_data,
  input logic [DW-1:0] rsp_data,
  input logic          ev_nack,
  input logic          ev_data_read,
  input logic          ev_inv_done
);

  // R7
  nack_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_nack |=> gnt_valid && gnt_excl);

  // R4
  inv_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_inv_done |=> gnt_valid && gnt_excl);

  // R4
  inv_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> inv_mask != '0);

  // R5
  fwd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> !req_ready);

  // R6
  read_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_data_read |=> gnt_valid && !gnt_excl && gnt_data == $past(rsp_data));

  // R10
  one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fwd_valid, inv_valid, gnt_valid}));

endmodule

bind dir_home dir_home_chk #(.NN(NN), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .fwd_valid(fwd_valid),
  .inv_valid(inv_valid), .inv_mask(inv_mask), .gnt_valid(gnt_valid),
  .gnt_excl(gnt_excl), .gnt_data(gnt_data), .rsp_data(rsp_data),
  .ev_nack(ev_nack), .ev_data_read(ev_data_read), .ev_inv_done(ev_inv_done)
);

// File: tb/dir_home_bench.sv
`timescale 1ns/1ps
module dir_home_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_node = '0;
  logic        req_op = 1'b0;
  logic [2:0]  req_blk = '0;
  logic        req_ready;
  logic        fwd_valid;
  logic [1:0]  fwd_node;
  logic        fwd_op;
  logic [2:0]  fwd_blk;
  logic        inv_valid;
  logic [3:0]  inv_mask;
  logic [2:0]  inv_blk;
  logic        rsp_valid = 1'b0;
  logic [1:0]  rsp_node = '0;
  logic [1:0]  rsp_kind = '0;
  logic [15:0] rsp_data = '0;
  logic        gnt_valid;
  logic [1:0]  gnt_node;
  logic        gnt_excl;
  logic [2:0]  gnt_blk;
  logic [15:0] gnt_data;

  always #2.5 clk = ~clk;

  dir_home u_dir_home (.*);

  int n_chk = 0;
  int n_fail = 0;

  // Reference model: 0 uncached, 1 shared, 2 held exclusively.
  int          m_st  [8];
  logic [3:0]  m_shr [8];
  int          m_own [8];
  logic [15:0] m_mem [8];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_gnt(input int n, input bit ex, input int b,
                            input logic [15:0] d, input string tag);
    chk(gnt_valid === 1'b1, {tag, " grant valid"}, gnt_valid, 1);
    chk(gnt_node == 2'(n) && gnt_excl == ex && gnt_blk == 3'(b),
        {tag, " grant fields"}, {gnt_node, gnt_excl, gnt_blk}, {2'(n), ex, 3'(b)});
    chk(gnt_data == d, {tag, " grant data"}, gnt_data, d);
    chk(fwd_valid === 1'b0 && inv_valid === 1'b0, {tag, " no other action"},
        {fwd_valid, inv_valid}, 0);
  endtask

  task automatic respond(input int n, input int k, input logic [15:0] d);
    rsp_valid = 1'b1; rsp_node = 2'(n); rsp_kind = 2'(k); rsp_data = d;
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  // One complete transaction predicted from the model.
  task automatic txn(input int n, input int op, input int b, input bit drop,
                     input logic [15:0] nd, input string tag);
    logic [3:0] oth;
    int last_i;
    @(negedge clk);
    chk(req_ready === 1'b1, {tag, " ready"}, req_ready, 1);
    req_valid = 1'b1; req_node = 2'(n); req_op = op[0]; req_blk = 3'(b);
    @(negedge clk);
    req_valid = 1'b0;
    if (m_st[b] == 0 || (m_st[b] == 2 && m_own[b] == n)) begin
      expect_gnt(n, 1, b, m_mem[b], {tag, " R2/R8 direct"});
      m_st[b] = 2; m_own[b] = n;
    end else if (m_st[b] == 1) begin
      if (op == 0) begin
        expect_gnt(n, 0, b, m_mem[b], {tag, " R3 shared"});
        m_shr[b] |= 4'(1 << n);
      end else begin
        oth = m_shr[b] & ~4'(1 << n);
        if (oth == 0) begin
          expect_gnt(n, 1, b, m_mem[b], {tag, " R4 sole"});
        end else begin
          chk(inv_valid === 1'b1 && inv_mask == oth && inv_blk == 3'(b) && !gnt_valid,
              {tag, " R4 invalidate"}, {inv_valid, inv_mask}, {1'b1, oth});
          last_i = 0;
          for (int i = 0; i < 4; i++) if (oth[i]) last_i = i;
          for (int i = 0; i < 4; i++) begin
            if (oth[i]) begin
              respond(i, 2, 16'h0);
              if (i != last_i)
                chk(gnt_valid === 1'b0, {tag, " R4 wait all acks"}, gnt_valid, 0);
              else
                expect_gnt(n, 1, b, m_mem[b], {tag, " R4 after acks"});
            end
          end
        end
        m_st[b] = 2; m_own[b] = n;
      end
    end else begin
      chk(fwd_valid === 1'b1 && fwd_node == 2'(m_own[b]) && fwd_op == op[0] &&
          fwd_blk == 3'(b) && req_ready === 1'b0 && !gnt_valid,
          {tag, " R5 forward"}, {fwd_valid, fwd_node, fwd_op, fwd_blk},
          {1'b1, 2'(m_own[b]), op[0], 3'(b)});
      if (drop) begin
        respond(m_own[b], 1, 16'h0);
        expect_gnt(n, 1, b, m_mem[b], {tag, " R7 nack"});
        m_own[b] = n;
      end else begin
        respond(m_own[b], 0, nd);
        m_mem[b] = nd;
        if (op == 0) begin
          expect_gnt(n, 0, b, nd, {tag, " R6 read data"});
          m_st[b] = 1; m_shr[b] = 4'(1 << n) | 4'(1 << m_own[b]);
        end else begin
          expect_gnt(n, 1, b, nd, {tag, " R6 own data"});
          m_own[b] = n;
        end
      end
    end
  endtask

  initial begin
    #20000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int b = 0; b < 8; b++) begin
      m_st[b] = 0; m_shr[b] = '0; m_own[b] = 0;
      m_mem[b] = 16'(32'hA000 + 32'(b) * 32'h111);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(req_ready === 1'b1 && gnt_valid === 1'b0 && fwd_valid === 1'b0 &&
        inv_valid === 1'b0, "R1 reset outputs",
        {req_ready, gnt_valid, fwd_valid, inv_valid}, 4'b1000);

    txn(0, 0, 1, 0, 16'h0, "R1 R2 read uncached");
    txn(1, 0, 1, 0, 16'h1234, "R6 read of held block");
    txn(2, 0, 1, 0, 16'h0, "R3 read shared");
    txn(3, 1, 1, 0, 16'h0, "R4 ownership of shared");
    txn(0, 0, 1, 1, 16'h0, "R7 stale holder");
    txn(0, 1, 1, 0, 16'h0, "R8 holder asks again");
    txn(2, 1, 2, 0, 16'h0, "R2 ownership uncached");
    txn(1, 1, 2, 0, 16'h5A5A, "R6 ownership transfer");
    txn(3, 0, 2, 1, 16'h0, "R7 read after drop");

    // R9: stray replies
    txn(0, 0, 5, 0, 16'h0, "R9 setup");
    @(negedge clk);
    respond(0, 0, 16'hDEAD);
    chk(gnt_valid === 1'b0 && req_ready === 1'b1, "R9 idle reply ignored",
        {gnt_valid, req_ready}, 2'b01);
    req_valid = 1'b1; req_node = 2'd1; req_op = 1'b1; req_blk = 3'd5;
    @(negedge clk);
    req_valid = 1'b0;
    chk(fwd_valid === 1'b1 && fwd_node == 2'd0, "R9 R5 forward", {fwd_valid, fwd_node}, 3'b100);
    respond(2, 0, 16'hBEEF);
    chk(gnt_valid === 1'b0 && req_ready === 1'b0, "R9 wrong node ignored",
        {gnt_valid, req_ready}, 2'b00);
    respond(0, 1, 16'h0);
    expect_gnt(1, 1, 5, m_mem[5], "R9 memory untouched");
    m_own[5] = 1;

    // R10: racing ownership requests
    txn(0, 0, 6, 0, 16'h0, "R10 setup");
    @(negedge clk);
    req_valid = 1'b1; req_node = 2'd1; req_op = 1'b1; req_blk = 3'd6;
    @(negedge clk);
    req_node = 2'd2;
    chk(fwd_valid === 1'b1 && fwd_node == 2'd0 && req_ready === 1'b0,
        "R10 first forward", {fwd_valid, fwd_node, req_ready}, 4'b1000);
    respond(0, 0, 16'h6666);
    expect_gnt(1, 1, 6, 16'h6666, "R10 first grant");
    chk(req_ready === 1'b1, "R10 ready in grant cycle", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(fwd_valid === 1'b1 && fwd_node == 2'd1 && fwd_op == 1'b1,
        "R10 second forward to new holder", {fwd_valid, fwd_node, fwd_op}, 4'b1011);
    respond(1, 0, 16'h7777);
    expect_gnt(2, 1, 6, 16'h7777, "R10 second grant");
    m_st[6] = 2; m_own[6] = 2; m_mem[6] = 16'h7777;

    txn(3, 0, 6, 0, 16'h0102, "R6 final read");

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule